// File: doc/BRIEF.md
# Per-Line Edge Interrupt Capture

This block holds the interrupt logic for the first three 8-bit ports of a digital I/O peripheral, 24 lines in total. Every line carries two configuration bits, an arm bit and an edge-select bit. A line's input is first resynchronised into the block clock domain. When an armed line shows the edge its edge-select bit asks for, a sticky event flag for that line is set.

Each port with at least one flagged line sets its own bit in a pending summary. A single request output is high whenever any summary bit is set. There is no write-one-to-clear. Software removes a flagged event by writing 0 to that line's arm bit and then writes 1 to arm the line again.

Register decoding sits in a separate block. That block reaches this one through a small write port, which selects a port index and either the arm or the edge-select byte. It reads back through a port-indexed read mux.

Top module: `edge_irq_capture`

## Requirements
- R1: After reset every arm bit, every edge-select bit and every event flag reads 0, the pending summary is 0 and `irq_o` is low.
- R2: A line with edge-select 1 and arm 1 sets its event flag on a 0-to-1 input change. The flag is readable on the third rising clock edge after the input changes. A 1-to-0 change does not set it.
- R3: A line with edge-select 0 and arm 1 sets its event flag on a 1-to-0 input change and not on a 0-to-1 change.
- R4: A line whose arm bit is 0 never holds a set event flag. Arming a line later does not capture an edge that happened while it was unarmed.
- R5: Pending summary bit p (p = 0, 1, 2) is 1 exactly when port p has any event flag set. Summary bits 7:3 always read 0.
- R6: Writing 0 to a line's arm bit clears that line's event flag at the same clock edge. Writing 1 again re-arms the line so that later edges are captured, and the cleared event does not return.
- R7: When a selected edge and a write of 0 to that line's arm bit fall on the same clock edge, the flag ends up clear.
- R8: `irq_o` is high while any pending summary bit is 1. It stays high after one port is cleared as long as another port still has a flag set.
- R9: An event flag stays set after the input returns to its previous level.
- R10: A configuration write changes only the byte of the port selected by `wr_port_i`. The bytes of the other ports keep their values.
- R11: Reading with `rd_port_i` = 3, which is not an interrupt port, returns 0 on all three read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 24 | Raw line inputs; bit 8*p+b is port p, bit b |
| arm_we_i | input | 1 | Write strobe for the arm byte of the selected port |
| sel_we_i | input | 1 | Write strobe for the edge-select byte (1 = rising) of the selected port |
| wr_port_i | input | 2 | Port index for a write |
| wr_data_i | input | 8 | Write data |
| rd_port_i | input | 2 | Port index for reads |
| rd_flag_o | output | 8 | Event flags of the read port |
| rd_arm_o | output | 8 | Arm byte of the read port |
| rd_sel_o | output | 8 | Edge-select byte of the read port |
| pend_o | output | 8 | Pending summary, bit p for port p |
| irq_o | output | 1 | Interrupt request |

## Verification
A flag that latches at the wrong moment or is lost shows up in the read-back flag byte, in the pending summary and on `irq_o`, all on the third rising edge after the input change. Checks are therefore made both one edge early and on time. A clear that fails to win over a simultaneous edge leaves a stray flag. That stray flag is visible the cycle after the write, and it is visible again after re-arming. A decode fault on the write side corrupts the bytes of neighbouring ports, and read-back of those bytes exposes it at once.

// File: rtl/eic_pkg.sv
package eic_pkg;
  // One line: does the pair (current, previous) form the selected edge?
  function automatic logic edge_hit(input logic cur, input logic old, input logic rise_sel);
    return rise_sel ? (cur & ~old) : (~cur & old);
  endfunction

  // Next event flag: a clear beats a simultaneous capture.
  function automatic logic flag_next(input logic flag, input logic cap, input logic clr);
    return clr ? 1'b0 : (flag | cap);
  endfunction
endpackage

// File: rtl/eic_sync_edge.sv
module eic_sync_edge #(
  parameter int WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q  <= '0;
      level_o <= '0;
      prev_o  <= '0;
    end else begin
      meta_q  <= pin_i;
      level_o <= meta_q;
      prev_o  <= level_o;
    end
  end
endmodule

// File: rtl/eic_port_capture.sv
module eic_port_capture
  import eic_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] level_i,
  input  logic [PORT_W-1:0] prev_i,
  input  logic              arm_we_i,
  input  logic              sel_we_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] arm_o,
  output logic [PORT_W-1:0] sel_o,
  output logic [PORT_W-1:0] flag_o,
  output logic [PORT_W-1:0] cap_o,
  output logic [PORT_W-1:0] clr_o
);
  logic [PORT_W-1:0] hit;
  logic [PORT_W-1:0] flag_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_o <= '0;
      sel_o <= '0;
    end else begin
      if (arm_we_i) arm_o <= wdata_i;
      if (sel_we_i) sel_o <= wdata_i;
    end
  end

  for (genvar b = 0; b < PORT_W; b++) begin : g_line
    assign hit[b]    = edge_hit(level_i[b], prev_i[b], sel_o[b]);
    assign cap_o[b]  = hit[b] & arm_o[b];
    assign clr_o[b]  = arm_we_i & ~wdata_i[b];
    assign flag_d[b] = flag_next(flag_o[b], cap_o[b], clr_o[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= flag_d;
  end
endmodule

// File: rtl/edge_irq_capture.sv
module edge_irq_capture #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8,
  parameter int PEND_W    = 8,
  localparam int NUM_LINES = NUM_PORTS * PORT_W,
  localparam int SEL_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS + 1) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 arm_we_i,
  input  logic                 sel_we_i,
  input  logic [SEL_W-1:0]     wr_port_i,
  input  logic [PORT_W-1:0]    wr_data_i,
  input  logic [SEL_W-1:0]     rd_port_i,
  output logic [PORT_W-1:0]    rd_flag_o,
  output logic [PORT_W-1:0]    rd_arm_o,
  output logic [PORT_W-1:0]    rd_sel_o,
  output logic [PEND_W-1:0]    pend_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] level, prev;
  logic [NUM_LINES-1:0] flag_flat, arm_flat, cap_flat, clr_flat;
  logic [PORT_W-1:0]    arm_a  [NUM_PORTS];
  logic [PORT_W-1:0]    sel_a  [NUM_PORTS];
  logic [PORT_W-1:0]    flag_a [NUM_PORTS];

  eic_sync_edge #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .level_o (level),
    .prev_o  (prev)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic arm_we, sel_we;
    logic [PORT_W-1:0] cap, clr;
    assign arm_we = arm_we_i && (wr_port_i == SEL_W'(p));
    assign sel_we = sel_we_i && (wr_port_i == SEL_W'(p));

    eic_port_capture #(.PORT_W(PORT_W)) u_cap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .level_i  (level[p*PORT_W +: PORT_W]),
      .prev_i   (prev[p*PORT_W +: PORT_W]),
      .arm_we_i (arm_we),
      .sel_we_i (sel_we),
      .wdata_i  (wr_data_i),
      .arm_o    (arm_a[p]),
      .sel_o    (sel_a[p]),
      .flag_o   (flag_a[p]),
      .cap_o    (cap),
      .clr_o    (clr)
    );

    assign flag_flat[p*PORT_W +: PORT_W] = flag_a[p];
    assign arm_flat[p*PORT_W +: PORT_W]  = arm_a[p];
    assign cap_flat[p*PORT_W +: PORT_W]  = cap;
    assign clr_flat[p*PORT_W +: PORT_W]  = clr;
  end

  always_comb begin
    rd_flag_o = '0;
    rd_arm_o  = '0;
    rd_sel_o  = '0;
    pend_o    = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      pend_o[p] = |flag_a[p];
      if (rd_port_i == SEL_W'(p)) begin
        rd_flag_o = flag_a[p];
        rd_arm_o  = arm_a[p];
        rd_sel_o  = sel_a[p];
      end
    end
  end

  assign irq_o = |pend_o;
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int NUM_LINES = 24,
  parameter int NUM_PORTS = 3,
  parameter int PEND_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] flag_flat,
  input logic [NUM_LINES-1:0] arm_flat,
  input logic [NUM_LINES-1:0] cap_flat,
  input logic [NUM_LINES-1:0] clr_flat,
  input logic [PEND_W-1:0]    pend_o,
  input logic                 irq_o
);
  // R4
  flag_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_flat & ~arm_flat) == '0);

  // R6
  clear_takes_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flag_flat & $past(clr_flat)) == '0);

  // R9
  flag_only_from_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flag_flat & ~$past(flag_flat) & ~$past(cap_flat)) == '0);

  // R8
  irq_follows_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag_flat != '0));

  // R5
  pend_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o >> NUM_PORTS) == '0);
endmodule

bind edge_irq_capture eic_checker #(
  .NUM_LINES (NUM_LINES),
  .NUM_PORTS (NUM_PORTS),
  .PEND_W    (PEND_W)
) u_eic_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flag_flat (flag_flat),
  .arm_flat  (arm_flat),
  .cap_flat  (cap_flat),
  .clr_flat  (clr_flat),
  .pend_o    (pend_o),
  .irq_o     (irq_o)
);

// File: tb/test_edge_irq_capture.sv
module test_edge_irq_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic        arm_we = 1'b0, sel_we = 1'b0;
  logic [1:0]  wr_port = '0, rd_port = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_flag, rd_arm, rd_sel, pend;
  logic        irq;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  edge_irq_capture i_edge_irq_capture (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins),
    .arm_we_i(arm_we), .sel_we_i(sel_we), .wr_port_i(wr_port), .wr_data_i(wr_data),
    .rd_port_i(rd_port), .rd_flag_o(rd_flag), .rd_arm_o(rd_arm), .rd_sel_o(rd_sel),
    .pend_o(pend), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit is_sel, input int port, input logic [7:0] data);
    @(negedge clk);
    arm_we = !is_sel; sel_we = is_sel; wr_port = 2'(port); wr_data = data;
    @(negedge clk);
    arm_we = 1'b0; sel_we = 1'b0;
  endtask

  task automatic peek(input int port, output logic [7:0] f, output logic [7:0] a, output logic [7:0] s);
    rd_port = 2'(port);
    #1;
    f = rd_flag; a = rd_arm; s = rd_sel;
  endtask

  task automatic t_reset();
    logic [7:0] f, a, s;
    for (int p = 0; p < 3; p++) begin
      peek(p, f, a, s);
      chk("R1 flag", f, 0); chk("R1 arm", a, 0); chk("R1 sel", s, 0);
    end
    chk("R1 pend", pend, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_rise();
    logic [7:0] f, a, s;
    wr(1, 0, 8'hFF); wr(0, 0, 8'hFF);
    @(negedge clk); pins[0] = 1'b1;
    cycles(2); peek(0, f, a, s); chk("R2 early", f, 0);
    cycles(1); peek(0, f, a, s); chk("R2 rise flag", f, 8'h01);
    chk("R5 pend p0", pend, 8'h01); chk("R8 irq", irq, 1);
    pins[0] = 1'b0; cycles(4);
    peek(0, f, a, s); chk("R9 sticky / R2 no fall", f, 8'h01);
    wr(0, 0, 8'h00); peek(0, f, a, s); chk("R6 clear", f, 0); chk("R8 irq low", irq, 0);
    wr(0, 0, 8'hFF); cycles(2); peek(0, f, a, s); chk("R6 no replay", f, 0);
  endtask

  task automatic t_fall();
    logic [7:0] f, a, s;
    wr(1, 1, 8'h00); wr(0, 1, 8'hFF);
    @(negedge clk); pins[15:8] = 8'hFF; cycles(4);
    peek(1, f, a, s); chk("R3 no rise capture", f, 0);
    pins[9] = 1'b0; cycles(3);
    peek(1, f, a, s); chk("R3 fall flag", f, 8'h02); chk("R5 pend p1", pend, 8'h02);
  endtask

  task automatic t_disarmed();
    logic [7:0] f, a, s;
    wr(1, 2, 8'hFF);
    @(negedge clk); pins[16] = 1'b1; cycles(4);
    peek(2, f, a, s); chk("R4 unarmed", f, 0); chk("R4 pend", pend, 8'h02);
    wr(0, 2, 8'hFF); cycles(2); peek(2, f, a, s); chk("R4 no late capture", f, 0);
    pins[16] = 1'b0; cycles(4); pins[16] = 1'b1; cycles(3);
    peek(2, f, a, s); chk("R4 armed capture", f, 8'h01); chk("R5 pend p1 p2", pend, 8'h06);
    peek(0, f, a, s); chk("R10 p0 arm kept", a, 8'hFF); chk("R10 p0 sel kept", s, 8'hFF);
    peek(1, f, a, s); chk("R10 p1 sel kept", s, 8'h00); chk("R10 p1 flag kept", f, 8'h02);
  endtask

  task automatic t_irq_hold();
    logic [7:0] f, a, s;
    wr(0, 1, 8'h00);
    chk("R8 irq held", irq, 1); chk("R8 pend p2 only", pend, 8'h04);
    wr(0, 2, 8'h00);
    chk("R8 irq drop", irq, 0); chk("R5 pend zero", pend, 0);
    peek(3, f, a, s); chk("R11 flag", f, 0); chk("R11 arm", a, 0); chk("R11 sel", s, 0);
  endtask

  task automatic t_priority();
    logic [7:0] f, a, s;
    @(negedge clk); pins[3] = 1'b1;
    cycles(2);
    arm_we = 1'b1; wr_port = 2'd0; wr_data = 8'hF7;
    @(negedge clk); arm_we = 1'b0;
    peek(0, f, a, s); chk("R7 clear wins", f, 0);
    wr(0, 0, 8'hFF); cycles(2); peek(0, f, a, s); chk("R7 stays clear", f, 0);
    pins[3] = 1'b0; cycles(4); peek(0, f, a, s); chk("R2 fall ignored", f, 0);
    pins[3] = 1'b1; cycles(3); peek(0, f, a, s); chk("R6 rearmed capture", f, 8'h08);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_rise();
    t_fall();
    t_disarmed();
    t_irq_hold();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule